// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an eight-bit general-purpose I/O port from a small byte-wide register interface. Software sets three registers: a data latch that holds the value to drive, a direction register that picks input or output for each pin, and an input-enable register. The input-enable register turns off the digital input path of pins used for analog signals. From these registers the block produces registered output-enable and output-data signals for tri-state pad drivers. It also brings the pin levels back in through a two-flop synchronizer.

The synchronized pin values can be read back. They are also passed to neighbouring interrupt logic, which detects edges on pins configured as inputs. A pin whose input is disabled reads back the latch value, and the value passed on for it is 0. The data latch has no reset, so software writes the output value first and sets the direction after. The block never drives a value on a pin whose driver is off. A low-power stop condition with the pin-state control set turns every driver off, whatever the direction register holds. In that condition the internal input is clamped to 0.

Top module: `gpio_port`

## Requirements
- R1: One clock edge after the write that sets a direction bit to 1 (direction register, offset 1), that pin's pad_oe is 1 and its pad_out equals the latch bit. With the direction bit at 0, pad_oe is 0.
- R2: A write to offset 0 updates the data latch whatever the direction bits hold. A pin in input mode holds the value without driving it, and the pin drives it as soon as its direction bit is set.
- R3: Any pad_out bit whose pad_oe bit is 0 reads 0, so an unwritten or stale latch value never appears on a pad.
- R4: A read of offset 0 returns the synchronized pin level for every bit whose input-enable bit is 1. This holds for input pins, output pins and pins used as interrupt inputs.
- R5: A bit whose input-enable bit (offset 2) is 0 reads back the data latch value at offset 0, and its pin_to_irq bit is 0.
- R6: Synchronous reset clears the direction register, sets input-enable to all ones, and clears pad_oe, pad_out, bus_rdata and pin_to_irq. Reset leaves the data latch unchanged.
- R7: While stop_mode and stop_pin_hiz are both 1, every pad_oe bit is 0 from the next clock edge on, whatever the direction register holds. When the stop condition ends, the drivers return to the direction setting.
- R8: During that stop condition the internal input is clamped to 0. pin_to_irq is 0, and bits with input-enable 1 read back 0.
- R9: stop_mode with stop_pin_hiz at 0 has no effect on pad_oe, pad_out or the read value.
- R10: A read of offset 1 returns the stored direction register. Offset 2 returns input-enable, and offset 3 returns 0.
- R11: A pin level change shows on pin_to_irq and on an offset-0 read exactly three clock edges after it is applied: two synchronizer flops, then the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for bus_addr |
| stop_mode | input | 1 | Low-power stop is active |
| stop_pin_hiz | input | 1 | Pin-state control: drivers off during stop |
| pin_in | input | 8 | Raw pin levels from the pads |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_out | output | 8 | Per-pin drive value |
| pin_to_irq | output | 8 | Synchronized, gated input toward interrupt logic |

## Verification
The bench builds the block with its default values: an eight-bit port and two synchronizer stages. With these values every bit of every register can be driven to both levels, and the three-edge input latency can be checked on the exact cycle. Random register writes, pin changes and stop toggles run through combinations of direction, input-enable and stop state. Directed cases cover an unwritten latch, latch retention across reset, the stop condition without pin-state control, and the unused address.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_INEN = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]      wdata,
  output logic [WIDTH-1:0]      latch_q,
  output logic [WIDTH-1:0]      dir_q,
  output logic [WIDTH-1:0]      inen_q
);
  logic sel_data, sel_dir, sel_inen;

  always_comb begin
    sel_data = wr_en && (addr == REG_DATA);
    sel_dir  = wr_en && (addr == REG_DIR);
    sel_inen = wr_en && (addr == REG_INEN);
  end

  // Data latch: deliberately outside reset.
  always_ff @(posedge clk) begin
    if (sel_data) latch_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      inen_q <= '1;
    end else begin
      if (sel_dir)  dir_q  <= wdata;
      if (sel_inen) inen_q <= wdata;
    end
  end

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && addr == REG_DATA && !rst) |-> latch_q == $past(wdata)); // R2

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && addr == REG_DIR) && !$past(rst) |-> $stable(dir_q)); // R1
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_off,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  logic [WIDTH-1:0] oe_next;

  always_comb begin
    oe_next = force_off ? '0 : dir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= oe_next;
      pad_out <= oe_next & latch_q;
    end
  end

  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~$past(dir_q)) == '0); // R1

  AST_STOP_DRV_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(force_off) |-> pad_oe == '0); // R7

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0); // R3
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [WIDTH-1:0]      bus_wdata,
  output logic [WIDTH-1:0]      bus_rdata,
  input  logic                  stop_mode,
  input  logic                  stop_pin_hiz,
  input  logic [WIDTH-1:0]      pin_in,
  output logic [WIDTH-1:0]      pad_oe,
  output logic [WIDTH-1:0]      pad_out,
  output logic [WIDTH-1:0]      pin_to_irq
);
  logic [WIDTH-1:0] latch_q, dir_q, inen_q, pin_sync;
  logic [WIDTH-1:0] pin_level, rd_next;
  logic             force_off;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .inen_q(inen_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  gpio_port_pad #(.WIDTH(WIDTH)) u_pad (
    .clk(clk), .rst(rst), .force_off(force_off), .dir_q(dir_q),
    .latch_q(latch_q), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  always_comb begin
    force_off = stop_mode & stop_pin_hiz;
    pin_level = force_off ? '0 : pin_sync;
    unique case (bus_addr)
      REG_DATA: rd_next = (pin_level & inen_q) | (latch_q & ~inen_q);
      REG_DIR:  rd_next = dir_q;
      REG_INEN: rd_next = inen_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      pin_to_irq <= '0;
    end else begin
      bus_rdata  <= rd_next;
      pin_to_irq <= pin_level & inen_q;
    end
  end

  AST_STOP_CLAMP: assert property (@(posedge clk) disable iff (rst)
    $past(force_off) |-> pin_to_irq == '0); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (pin_to_irq & ~$past(inen_q)) == '0); // R5
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   bus_addr;
  logic         bus_wr;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic         stop_mode, stop_pin_hiz;
  logic [W-1:0] pin_in, pad_oe, pad_out, pin_to_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [W-1:0] m_latch, m_dir, m_ien, m_pin;
  logic         m_stop, m_hiz;

  gpio_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_mode(stop_mode),
    .stop_pin_hiz(stop_pin_hiz), .pin_in(pin_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pin_to_irq(pin_to_irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic fo();
    return m_stop & m_hiz;
  endfunction
  function automatic logic [W-1:0] exp_oe();
    return fo() ? '0 : m_dir;
  endfunction
  function automatic logic [W-1:0] exp_out();
    return exp_oe() & m_latch;
  endfunction
  function automatic logic [W-1:0] exp_data();
    logic [W-1:0] lvl = fo() ? '0 : m_pin;
    return (lvl & m_ien) | (m_latch & ~m_ien);
  endfunction
  function automatic logic [W-1:0] exp_irq();
    return fo() ? '0 : (m_pin & m_ien);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      2'd0: m_latch = d;
      2'd1: m_dir = d;
      2'd2: m_ien = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] d;
    check({tag, " oe"}, pad_oe, exp_oe());
    check({tag, " out"}, pad_out, exp_out());
    check({tag, " irq"}, pin_to_irq, exp_irq());
    rd(2'd0, d); check({tag, " data"}, d, exp_data());
    rd(2'd1, d); check({tag, " dir"}, d, m_dir);
    rd(2'd2, d); check({tag, " ien"}, d, m_ien);
  endtask

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    stop_mode = 1'b0; stop_pin_hiz = 1'b0; pin_in = '0;
    m_dir = '0; m_ien = '1; m_pin = '0; m_stop = 0; m_hiz = 0; m_latch = '0;
    tick(3);
    rst = 1'b0;
    // R6 reset state, latch never written: R3 no drive
    check("R6 oe", pad_oe, '0);
    check("R3 out", pad_out, '0);
    check("R6 rdata", bus_rdata, '0);
    check("R6 irq", pin_to_irq, '0);
    rd(2'd1, d); check("R6 dir", d, '0);
    rd(2'd2, d); check("R6 ien", d, 8'hFF);
    rd(2'd3, d); check("R10 unused", d, '0);

    // R2: write latch in input mode, nothing driven
    wr(2'd0, 8'h3C); tick(1);
    check("R2 held oe", pad_oe, '0);
    check("R3 held out", pad_out, '0);
    // R1: direction set, drive one edge after write edge
    bus_addr = 2'd1; bus_wr = 1'b1; bus_wdata = 8'h0F;
    @(negedge clk); bus_wr = 1'b0; m_dir = 8'h0F;
    check("R1 oe at write edge", pad_oe, '0);
    tick(1);
    check("R1 oe", pad_oe, 8'h0F);
    check("R1 out", pad_out, 8'h0C);

    // R11: exact three-edge input latency
    pin_in = 8'hA5;
    tick(2);
    check("R11 irq before", pin_to_irq, '0);
    tick(1);
    check("R11 irq at 3", pin_to_irq, 8'hA5);
    m_pin = 8'hA5;
    rd(2'd0, d); check("R4 read pin", d, 8'hA5);

    // R5: input-enable off for low nibble
    wr(2'd2, 8'hF0); tick(1);
    rd(2'd0, d); check("R5 read latch", d, 8'hA0 | 8'h0C);
    check("R5 irq gated", pin_to_irq, 8'hA0);

    // R9: stop without pin-state control
    stop_mode = 1'b1; m_stop = 1; tick(2);
    check_all("R9");
    // R7/R8: stop with pin-state control
    stop_pin_hiz = 1'b1; m_hiz = 1; tick(1);
    check("R7 oe off", pad_oe, '0);
    check("R8 clamp irq", pin_to_irq, '0);
    check_all("R8");
    stop_mode = 1'b0; m_stop = 0; tick(1);
    check("R7 restore", pad_oe, 8'h0F);
    stop_pin_hiz = 1'b0; m_hiz = 0;

    // R6: latch survives reset
    wr(2'd0, 8'h96);
    rst = 1'b1; tick(2); rst = 1'b0;
    m_dir = '0; m_ien = '1;
    wr(2'd2, 8'h00); tick(1);
    rd(2'd0, d); check("R6 latch kept", d, 8'h96);

    // Random mix: R1 R2 R4 R5 R7 R8 R9 R10
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 4);
      case (op)
        0, 1: wr(2'($urandom_range(0, 3)), 8'($urandom));
        2: begin pin_in = 8'($urandom); m_pin = pin_in; end
        3: begin stop_mode = 1'($urandom); m_stop = stop_mode; end
        default: begin stop_pin_hiz = 1'($urandom); m_hiz = stop_pin_hiz; end
      endcase
      tick(4);
      check_all("R1/R4/R5/R7/R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule